// File: doc/BRIEF.md
# Mode-Banked Processor Register File

This block stores the architectural state of a 32-bit RISC core that runs in several processor modes. Software always addresses sixteen registers, indices 0 to 15, but for some of those indices the physical register behind the index changes with the current mode. Each exception mode therefore gets private copies of its stack pointer and link register without any save or restore code. The fast-interrupt mode also gets private copies of a larger group of registers. Behind the sixteen visible indices there are 31 general 32-bit registers and 6 status registers, 37 in all.

The core reaches the storage through two combinational read ports and one write port, each addressed by a 4-bit index. A dedicated port carries the program counter (index 15). A link strobe copies the program counter into index 14 of the current mode for branch-and-link. A current status word holds the condition flags, two interrupt-disable bits and a 5-bit mode field. A saved status word, one per exception mode, is visible only while that mode is active. All writes take effect on the rising clock edge. Reads return the stored value as it is before that edge.

Top module: `banked_regfile`

## Requirements
- R1: Indices 0 to 7 and 15 map to the same physical registers in every mode.
- R2: Fast-interrupt mode (mode field 5'b10001) has its own physical registers for indices 8 to 14. Every other mode uses the shared set for indices 8 to 12.
- R3: Interrupt (5'b10010), supervisor (5'b10011), abort (5'b10111) and undefined (5'b11011) modes each have their own physical registers for indices 13 and 14. User (5'b10000) and system (5'b11111) modes share one set.
- R4: Any mode field value other than the seven listed in R2 and R3 accesses the registers exactly as user mode does.
- R5: A write through the write port takes effect at the rising clock edge. A read of the same register in that cycle returns the old value.
- R6: pc_out always shows index 15. pc_wr_en loads index 15. If the write port also targets index 15 in the same cycle, the write port wins.
- R7: link_en copies the value of index 15 from before the edge into index 14 of the current mode. It takes priority over a write-port write to index 14 in the same cycle.
- R8: The current status word keeps bits 31 (N), 30 (Z), 29 (C), 28 (V), 7 (interrupt disable), 6 (fast-interrupt disable) and 4:0 (mode). All other bits read zero.
- R9: Each of the five exception modes has its own saved status word, visible on spsr_out and written by spsr_wr_en. In user, system or unlisted modes spsr_out reads zero and spsr writes are ignored.
- R10: After reset the current status word is 32'h000000D3 (supervisor, both interrupts disabled) and index 15 is zero. All general registers and saved status words are also cleared.
- R11: A status write that changes the mode affects register mapping from the next cycle on. A write-port access in the same cycle uses the old mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_a_idx | input | 4 | Read port A index |
| rd_a_data | output | 32 | Read port A data |
| rd_b_idx | input | 4 | Read port B index |
| rd_b_data | output | 32 | Read port B data |
| wr_en | input | 1 | Write port enable |
| wr_idx | input | 4 | Write port index |
| wr_data | input | 32 | Write port data |
| pc_out | output | 32 | Current program counter (index 15) |
| pc_wr_en | input | 1 | Program counter load enable |
| pc_wr_data | input | 32 | Program counter load value |
| link_en | input | 1 | Copy index 15 into index 14 of the current mode |
| cpsr_out | output | 32 | Current status word |
| cpsr_wr_en | input | 1 | Current status write enable |
| cpsr_wr_data | input | 32 | Current status write value |
| spsr_out | output | 32 | Saved status word of the current mode |
| spsr_wr_en | input | 1 | Saved status write enable |
| spsr_wr_data | input | 32 | Saved status write value |

## Verification
Two pairs of functions can collide in one cycle: a mode change with a register write, and the link copy or program-counter load with a write-port write to the same index. The bench drives each pair in a single cycle: a status write to fast-interrupt mode together with a write to index 9, a link strobe together with a write to index 14, and a program-counter load together with a write to index 15. It then reads back from both modes through the read ports. The write must land in the old mode's bank, the link copy must win at index 14, and the write port must win at index 15.

// File: rtl/rf_pkg.sv
package rf_pkg;
    localparam int XLEN       = 32;
    localparam int IDX_W      = 4;
    localparam int ARCH_REGS  = 1 << IDX_W;
    localparam int PC_IDX     = ARCH_REGS - 1;
    localparam int LINK_IDX   = ARCH_REGS - 2;
    localparam int SP_IDX     = ARCH_REGS - 3;
    localparam int FIQ_LO     = 8;
    localparam int FIQ_CNT    = LINK_IDX - FIQ_LO + 1;
    localparam int SHR_MODES  = 4;
    localparam int SHR_CNT    = LINK_IDX - SP_IDX + 1;
    localparam int FIQ_BASE   = ARCH_REGS;
    localparam int SHR_BASE   = FIQ_BASE + FIQ_CNT;
    localparam int PHYS_GPR   = SHR_BASE + SHR_MODES * SHR_CNT;
    localparam int PHYS_W     = $clog2(PHYS_GPR);
    localparam int SPSR_CNT   = 1 + SHR_MODES;

    localparam logic [4:0] MODE_USR = 5'b10000;
    localparam logic [4:0] MODE_FIQ = 5'b10001;
    localparam logic [4:0] MODE_IRQ = 5'b10010;
    localparam logic [4:0] MODE_SVC = 5'b10011;
    localparam logic [4:0] MODE_ABT = 5'b10111;
    localparam logic [4:0] MODE_UND = 5'b11011;
    localparam logic [4:0] MODE_SYS = 5'b11111;

    localparam int BIT_N = 31;
    localparam int BIT_Z = 30;
    localparam int BIT_C = 29;
    localparam int BIT_V = 28;
    localparam int BIT_I = 7;
    localparam int BIT_F = 6;

    localparam logic [XLEN-1:0] STATUS_MASK =
        (XLEN'(1) << BIT_N) | (XLEN'(1) << BIT_Z) | (XLEN'(1) << BIT_C) |
        (XLEN'(1) << BIT_V) | (XLEN'(1) << BIT_I) | (XLEN'(1) << BIT_F) |
        XLEN'(5'h1F);

    localparam logic [XLEN-1:0] STATUS_RESET =
        (XLEN'(1) << BIT_I) | (XLEN'(1) << BIT_F) | XLEN'(MODE_SVC);

    typedef enum logic [2:0] {
        MC_USR = 3'd0,
        MC_FIQ = 3'd1,
        MC_IRQ = 3'd2,
        MC_SVC = 3'd3,
        MC_ABT = 3'd4,
        MC_UND = 3'd5
    } mode_cls_e;

    typedef logic [XLEN-1:0] word_t;
    typedef logic [PHYS_W-1:0] phys_t;
endpackage

// File: rtl/rf_mode_decode.sv
module rf_mode_decode
    import rf_pkg::*;
(
    input  logic [4:0] mode_bits,
    output mode_cls_e  mode_cls
);
    always_comb begin
        unique case (mode_bits)
            MODE_FIQ: mode_cls = MC_FIQ;
            MODE_IRQ: mode_cls = MC_IRQ;
            MODE_SVC: mode_cls = MC_SVC;
            MODE_ABT: mode_cls = MC_ABT;
            MODE_UND: mode_cls = MC_UND;
            default:  mode_cls = MC_USR;
        endcase
    end
endmodule

// File: rtl/rf_bank_map.sv
module rf_bank_map
    import rf_pkg::*;
(
    input  logic [IDX_W-1:0] arch_idx,
    input  mode_cls_e        mode_cls,
    output phys_t            phys_idx
);
    localparam int SHR_SEL_W = $clog2(SHR_MODES);

    logic                  in_fiq_range;
    logic                  in_shr_range;
    logic                  is_shr_mode;
    logic [SHR_SEL_W-1:0]  shr_sel;
    logic [IDX_W-1:0]      fiq_off;
    logic [IDX_W-1:0]      shr_off;

    always_comb begin
        in_fiq_range = (int'(arch_idx) >= FIQ_LO) && (int'(arch_idx) <= LINK_IDX);
        in_shr_range = (int'(arch_idx) >= SP_IDX) && (int'(arch_idx) <= LINK_IDX);
        is_shr_mode  = (mode_cls == MC_IRQ) || (mode_cls == MC_SVC) ||
                       (mode_cls == MC_ABT) || (mode_cls == MC_UND);
        shr_sel      = SHR_SEL_W'(int'(mode_cls) - int'(MC_IRQ));
        fiq_off      = arch_idx - IDX_W'(FIQ_LO);
        shr_off      = arch_idx - IDX_W'(SP_IDX);

        if (mode_cls == MC_FIQ && in_fiq_range) begin
            phys_idx = PHYS_W'(FIQ_BASE + int'(fiq_off));
        end else if (is_shr_mode && in_shr_range) begin
            phys_idx = PHYS_W'(SHR_BASE + int'(shr_sel) * SHR_CNT + int'(shr_off));
        end else begin
            phys_idx = PHYS_W'(arch_idx);
        end
    end
endmodule

// File: rtl/rf_status_bank.sv
module rf_status_bank
    import rf_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  mode_cls_e  mode_cls,
    input  logic       cpsr_wr_en,
    input  word_t      cpsr_wr_data,
    input  logic       spsr_wr_en,
    input  word_t      spsr_wr_data,
    output word_t      cpsr_q_out,
    output word_t      spsr_rd
);
    localparam int SEL_W = $clog2(SPSR_CNT);

    typedef struct packed {
        word_t                  cpsr;
        word_t [SPSR_CNT-1:0]   spsr;
    } status_state_t;

    status_state_t st_d, st_q;
    logic          has_spsr;
    logic [SEL_W-1:0] sel;

    always_comb begin
        has_spsr = (mode_cls != MC_USR);
        sel      = SEL_W'(int'(mode_cls) - int'(MC_FIQ));
        st_d     = st_q;
        if (cpsr_wr_en) begin
            st_d.cpsr = cpsr_wr_data & STATUS_MASK;
        end
        if (spsr_wr_en && has_spsr) begin
            for (int k = 0; k < SPSR_CNT; k++) begin
                if (SEL_W'(k) == sel) begin
                    st_d.spsr[k] = spsr_wr_data;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cpsr <= STATUS_RESET;
            st_q.spsr <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        cpsr_q_out = st_q.cpsr;
        spsr_rd    = '0;
        if (has_spsr) begin
            for (int k = 0; k < SPSR_CNT; k++) begin
                if (SEL_W'(k) == sel) begin
                    spsr_rd = st_q.spsr[k];
                end
            end
        end
    end
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
    import rf_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [IDX_W-1:0]   rd_a_idx,
    output logic [XLEN-1:0]    rd_a_data,
    input  logic [IDX_W-1:0]   rd_b_idx,
    output logic [XLEN-1:0]    rd_b_data,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [XLEN-1:0]    wr_data,
    output logic [XLEN-1:0]    pc_out,
    input  logic               pc_wr_en,
    input  logic [XLEN-1:0]    pc_wr_data,
    input  logic               link_en,
    output logic [XLEN-1:0]    cpsr_out,
    input  logic               cpsr_wr_en,
    input  logic [XLEN-1:0]    cpsr_wr_data,
    output logic [XLEN-1:0]    spsr_out,
    input  logic               spsr_wr_en,
    input  logic [XLEN-1:0]    spsr_wr_data
);
    localparam int MAP_PORTS = 4;
    localparam int MP_RDA    = 0;
    localparam int MP_RDB    = 1;
    localparam int MP_WR     = 2;
    localparam int MP_LINK   = 3;

    typedef struct packed {
        word_t [PHYS_GPR-1:0] gpr;
    } gpr_state_t;

    gpr_state_t gpr_d, gpr_q;
    mode_cls_e  cur_cls;
    word_t      cpsr_cur;

    logic [IDX_W-1:0] map_in  [MAP_PORTS];
    phys_t            map_out [MAP_PORTS];

    rf_status_bank u_status (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode_cls     (cur_cls),
        .cpsr_wr_en   (cpsr_wr_en),
        .cpsr_wr_data (cpsr_wr_data),
        .spsr_wr_en   (spsr_wr_en),
        .spsr_wr_data (spsr_wr_data),
        .cpsr_q_out   (cpsr_cur),
        .spsr_rd      (spsr_out)
    );

    rf_mode_decode u_mode (
        .mode_bits (cpsr_cur[4:0]),
        .mode_cls  (cur_cls)
    );

    always_comb begin
        map_in[MP_RDA]  = rd_a_idx;
        map_in[MP_RDB]  = rd_b_idx;
        map_in[MP_WR]   = wr_idx;
        map_in[MP_LINK] = IDX_W'(LINK_IDX);
    end

    generate
        for (genvar g = 0; g < MAP_PORTS; g++) begin : g_map
            rf_bank_map u_map (
                .arch_idx (map_in[g]),
                .mode_cls (cur_cls),
                .phys_idx (map_out[g])
            );
        end
    endgenerate

    // Later assignments win: pc load, then write port, then link copy.
    always_comb begin
        gpr_d = gpr_q;
        if (pc_wr_en) begin
            gpr_d.gpr[PC_IDX] = pc_wr_data;
        end
        if (wr_en) begin
            gpr_d.gpr[map_out[MP_WR]] = wr_data;
        end
        if (link_en) begin
            gpr_d.gpr[map_out[MP_LINK]] = gpr_q.gpr[PC_IDX];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gpr_q <= '0;
        end else begin
            gpr_q <= gpr_d;
        end
    end

    always_comb begin
        rd_a_data = gpr_q.gpr[map_out[MP_RDA]];
        rd_b_data = gpr_q.gpr[map_out[MP_RDB]];
        pc_out    = gpr_q.gpr[PC_IDX];
        cpsr_out  = cpsr_cur;
    end
endmodule

// File: rtl/banked_regfile_checker.sv
module banked_regfile_checker
    import rf_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic [IDX_W-1:0]   rd_a_idx,
    input logic [XLEN-1:0]    rd_a_data,
    input logic               wr_en,
    input logic [IDX_W-1:0]   wr_idx,
    input logic [XLEN-1:0]    pc_out,
    input logic               pc_wr_en,
    input logic [XLEN-1:0]    pc_wr_data,
    input logic               link_en,
    input logic [XLEN-1:0]    cpsr_out,
    input logic               cpsr_wr_en,
    input logic [XLEN-1:0]    cpsr_wr_data,
    input logic [XLEN-1:0]    spsr_out
);
    logic exc_mode;
    always_comb begin
        exc_mode = (cpsr_out[4:0] == MODE_FIQ) || (cpsr_out[4:0] == MODE_IRQ) ||
                   (cpsr_out[4:0] == MODE_SVC) || (cpsr_out[4:0] == MODE_ABT) ||
                   (cpsr_out[4:0] == MODE_UND);
    end

    assert_reset_state_R10: assert property (@(posedge clk)
        !rst_n |=> (pc_out == '0 && cpsr_out == STATUS_RESET));

    assert_pc_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_wr_en && !(wr_en && wr_idx == IDX_W'(PC_IDX)))
        |=> pc_out == $past(pc_wr_data));

    assert_status_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cpsr_wr_en |=> cpsr_out == ($past(cpsr_wr_data) & STATUS_MASK));

    assert_spsr_hidden_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !exc_mode |-> spsr_out == '0);

    assert_read_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !link_en && !pc_wr_en && !cpsr_wr_en)
        |=> (rd_a_idx != $past(rd_a_idx)) || (rd_a_data == $past(rd_a_data)));
endmodule

bind banked_regfile banked_regfile_checker u_chk (.*);

// File: tb/banked_regfile_test.sv
module banked_regfile_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
    logic [31:0] rd_a_data, rd_b_data, pc_out, cpsr_out, spsr_out;
    logic        wr_en = 1'b0, pc_wr_en = 1'b0, link_en = 1'b0;
    logic        cpsr_wr_en = 1'b0, spsr_wr_en = 1'b0;
    logic [31:0] wr_data = '0, pc_wr_data = '0, cpsr_wr_data = '0, spsr_wr_data = '0;

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;

    logic [31:0] model [31];
    logic [31:0] smodel [8];
    logic [4:0]  modes [8] = '{5'b10000, 5'b10001, 5'b10010, 5'b10011,
                               5'b10111, 5'b11011, 5'b11111, 5'b00000};

    always #10 clk = ~clk;

    banked_regfile uut (.*);

    // Independent model: group number for (mode, index).
    function automatic int grp(logic [4:0] m, int idx);
        int slot;
        slot = -1;
        case (m)
            5'b10010: slot = 0;
            5'b10011: slot = 1;
            5'b10111: slot = 2;
            5'b11011: slot = 3;
            default:  slot = -1;
        endcase
        if (m == 5'b10001 && idx >= 8 && idx <= 14) return 16 + (idx - 8);
        if (slot >= 0 && (idx == 13 || idx == 14)) return 23 + 2 * slot + (idx - 13);
        return idx;
    endfunction

    function automatic bit is_exc(logic [4:0] m);
        return (m == 5'b10001) || (m == 5'b10010) || (m == 5'b10011) ||
               (m == 5'b10111) || (m == 5'b11011);
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic set_mode(logic [4:0] m);
        cpsr_wr_en   = 1'b1;
        cpsr_wr_data = 32'h000000C0 | {27'h0, m};
        @(negedge clk);
        cpsr_wr_en   = 1'b0;
    endtask

    initial begin
        #(20 * 20000);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 31; i++) model[i] = '0;
        for (int i = 0; i < 8; i++) smodel[i] = '0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 reset state
        check("R10 pc", pc_out, 32'h0);
        check("R10 cpsr", cpsr_out, 32'h000000D3);
        check("R10 spsr", spsr_out, 32'h0);
        rd_a_idx = 4'd13; #1;
        check("R10 gpr", rd_a_data, 32'h0);

        // Write every index 0..14 in every mode
        for (int mi = 0; mi < 8; mi++) begin
            set_mode(modes[mi]);
            for (int idx = 0; idx < 15; idx++) begin
                wr_en   = 1'b1;
                wr_idx  = 4'(idx);
                wr_data = 32'hA0000000 | (mi << 8) | idx;
                model[grp(modes[mi], idx)] = wr_data;
                @(negedge clk);
            end
            wr_en = 1'b0;
        end
        pc_wr_en = 1'b1; pc_wr_data = 32'h00000100;
        @(negedge clk);
        pc_wr_en = 1'b0;
        check("R6 pc load", pc_out, 32'h00000100);

        // Read back all indices from all modes on both ports
        for (int mi = 0; mi < 8; mi++) begin
            set_mode(modes[mi]);
            for (int idx = 0; idx < 16; idx++) begin
                string tag;
                logic [31:0] ea, eb;
                rd_a_idx = 4'(idx);
                rd_b_idx = 4'(15 - idx);
                #1;
                ea = (idx == 15) ? 32'h100 : model[grp(modes[mi], idx)];
                eb = (idx == 0)  ? 32'h100 : model[grp(modes[mi], 15 - idx)];
                if (idx < 8 || idx == 15) tag = "R1";
                else if (mi == 7) tag = "R4";
                else if (mi == 1) tag = "R2";
                else tag = "R3";
                check(tag, rd_a_data, ea);
                check(tag, rd_b_data, eb);
                @(negedge clk);
            end
        end

        // R5 same-cycle read returns old value
        wr_en = 1'b1; wr_idx = 4'd3; wr_data = 32'h33333333; rd_a_idx = 4'd3;
        #1;
        check("R5 old", rd_a_data, model[3]);
        @(negedge clk);
        wr_en = 1'b0;
        model[3] = 32'h33333333;
        check("R5 new", rd_a_data, 32'h33333333);

        // R6 collision: write port beats pc load
        pc_wr_en = 1'b1; pc_wr_data = 32'h200;
        wr_en = 1'b1; wr_idx = 4'd15; wr_data = 32'h300;
        @(negedge clk);
        pc_wr_en = 1'b0; wr_en = 1'b0;
        check("R6 collide", pc_out, 32'h300);

        // R7 link in supervisor mode
        set_mode(5'b10011);
        link_en = 1'b1;
        pc_wr_en = 1'b1; pc_wr_data = 32'h400;
        @(negedge clk);
        link_en = 1'b0; pc_wr_en = 1'b0;
        rd_a_idx = 4'd14; #1;
        check("R7 link", rd_a_data, 32'h300);
        link_en = 1'b1; wr_en = 1'b1; wr_idx = 4'd14; wr_data = 32'hDEADBEEF;
        @(negedge clk);
        link_en = 1'b0; wr_en = 1'b0;
        check("R7 priority", rd_a_data, 32'h400);
        model[grp(5'b10011, 14)] = 32'h400;
        set_mode(5'b10000);
        #1;
        check("R7 user r14 untouched", rd_a_data, model[14]);

        // R9 saved status per mode
        for (int mi = 0; mi < 8; mi++) begin
            set_mode(modes[mi]);
            spsr_wr_en = 1'b1; spsr_wr_data = 32'h55000000 | (mi << 4);
            if (is_exc(modes[mi])) smodel[mi] = spsr_wr_data;
            @(negedge clk);
            spsr_wr_en = 1'b0;
        end
        for (int mi = 0; mi < 8; mi++) begin
            set_mode(modes[mi]);
            check("R9 spsr", spsr_out, is_exc(modes[mi]) ? smodel[mi] : 32'h0);
        end

        // R11 mode change and write in one cycle
        set_mode(5'b10000);
        cpsr_wr_en = 1'b1; cpsr_wr_data = 32'h000000D1;
        wr_en = 1'b1; wr_idx = 4'd9; wr_data = 32'h11111111;
        @(negedge clk);
        cpsr_wr_en = 1'b0; wr_en = 1'b0;
        rd_a_idx = 4'd9; #1;
        check("R11 fiq r9 kept", rd_a_data, model[grp(5'b10001, 9)]);
        model[9] = 32'h11111111;
        set_mode(5'b10000);
        #1;
        check("R11 user r9 written", rd_a_data, 32'h11111111);

        // R8 status masking
        cpsr_wr_en = 1'b1; cpsr_wr_data = 32'hFFFFFFFF;
        @(negedge clk);
        cpsr_wr_en = 1'b0;
        check("R8 mask", cpsr_out, 32'hF00000DF);
        cpsr_wr_en = 1'b1; cpsr_wr_data = 32'h5FFFFF20;
        @(negedge clk);
        cpsr_wr_en = 1'b0;
        check("R8 mask2", cpsr_out, 32'h50000000);
        check("R9 illegal spsr", spsr_out, 32'h0);
        rd_a_idx = 4'd14; #1;
        check("R4 illegal r14", rd_a_data, model[14]);

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule